// File: doc/BRIEF.md
# Time-of-Day Counter with Button Setting

This block keeps the time of day as hours, minutes and seconds, advancing on a one-cycle pulse that arrives once per second. A second one-cycle pulse at 2 Hz drives button auto-repeat and the power-fail blink. Two active-high set buttons (hour, minute) edit either the running time or a separate alarm register. Their effect depends on the display mode chosen by two select inputs. The block presents four display digit codes, an AM/PM flag and a segment-enable gate. These feed an external multiplexer and segment decoder.

Hours are held internally on a 0..23 scale, and the 12/24-hour input affects only presentation. Midnight shows as 00 in 24-hour format and as 12 (AM) in 12-hour format. A set-control state machine sits between the buttons and the registers. It has four states:
- `ST_IDLE`: no button held.
- `ST_DELAY`: a button is held and the block waits out the first 2 Hz tick.
- `ST_REPEAT`: each 2 Hz tick advances the held fields.
- `ST_LOCK`: entered on a two-button reset or freeze. It ignores every set function until both buttons are up.

The state machine has these transitions:
- press: `ST_IDLE` to `ST_DELAY`.
- arm: `ST_DELAY` to `ST_REPEAT` on a 2 Hz tick.
- dual: any non-lock state to `ST_LOCK` when both buttons are held in alarm or seconds mode.
- release: any state to `ST_IDLE` when no button is held.

Top module: `tod_keeper`

## Requirements
- R1: The synchronous reset `rst` brings the block to a defined state:
  - The time is 00:00:00 and the alarm is 0:00.
  - The power-fail flag is 1, `seg_on` is 1 and the set state machine is idle.
- R2: Each `tick_1hz` pulse adds one second. The carry passes from 59 seconds into the minutes and from 59 minutes into the hours. After 23:59:59 the time becomes 00:00:00.
- R3: In time mode, the rising edge of `set_hr` adds one hour (23 wraps to 0) on the next clock edge. `set_min` does the same for the minutes (59 wraps to 00) and never carries into the hours. Both pressed together advance both fields.
- R4: While a set button stays held, the first `tick_2hz` pulse after the press changes nothing. Every later `tick_2hz` pulse advances the held field by one.
- R5: In alarm mode, the set buttons act on the alarm hour and minute registers exactly as in R3 and R4, and leave the running time untouched.
- R6: In alarm mode, holding both buttons clears the alarm to 0:00. After that, no set function acts until both buttons have been released.
- R7: In seconds mode, the first button press clears the seconds to 00. If the seconds were 50..59 at that moment, the minutes also increase by one, wrapping with no carry into the hours.
- R8: In seconds mode, holding both buttons freezes timekeeping: `tick_1hz` is ignored until both buttons are released.
- R9: The mode select inputs decode as follows:
  - `sel_alarm`=0, `sel_aux`=0: time mode.
  - `sel_alarm`=1, `sel_aux`=0: alarm mode.
  - `sel_alarm`=1, `sel_aux`=1: seconds mode.
  - `sel_alarm`=0, `sel_aux`=1: view mode.

  In time, view and alarm mode the digits are as follows. Time and view mode show the time; alarm mode shows the alarm.
  - `digit3`: hour tens.
  - `digit2`: hour units.
  - `digit1`: minute tens.
  - `digit0`: minute units.

  The hour is shown as 0..23 when `fmt_12h`=0. When `fmt_12h`=1 it is shown as 1..12, where hour 0 shows 12 and hours 13..23 show 1..11.
- R10: In seconds mode the digits are as follows:
  - `digit3`: the blank code 15.
  - `digit2`: minute units.
  - `digit1`: second tens.
  - `digit0`: second units.
- R11: `pm` is 1 only when `fmt_12h`=1, the mode is not seconds mode and the displayed hour is 12..23.
- R12: View mode shows the running time and ignores both set buttons.
- R13: The power-fail flag `pwr_fail` clears when either set button is high.
  - While the flag is set, `seg_on` toggles on every `tick_2hz` pulse, a 1 Hz blink.
  - While the flag is clear, `seg_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle pulse per second |
| tick_2hz | input | 1 | One-cycle pulse at 2 Hz |
| set_hr | input | 1 | Hour set button, active high |
| set_min | input | 1 | Minute set button, active high |
| sel_alarm | input | 1 | Display select A |
| sel_aux | input | 1 | Display select B |
| fmt_12h | input | 1 | 1 = 12-hour display, 0 = 24-hour |
| hours | output | 5 | Running hours, 0..23 |
| minutes | output | 6 | Running minutes |
| seconds | output | 6 | Running seconds |
| alarm_hours | output | 5 | Alarm hours, 0..23 |
| alarm_minutes | output | 6 | Alarm minutes |
| pm | output | 1 | PM indicator for the displayed hour |
| digit3 | output | 4 | Leftmost digit code |
| digit2 | output | 4 | Second digit code |
| digit1 | output | 4 | Third digit code |
| digit0 | output | 4 | Rightmost digit code |
| seg_on | output | 1 | Segment enable (blink gate) |
| pwr_fail | output | 1 | Power-fail flag |

## Verification
Every register-held result appears one clock edge after the stimulus that causes it. This covers the time, the alarm, the power-fail flag and the blink phase. An input held in the cycle before an edge takes effect at that edge, and the digits and `pm` follow the registers and `fmt_12h` combinationally. The bench changes inputs on the falling clock edge, allows exactly one rising edge, and reads outputs at the following falling edge. Tick pulses and button presses never share a cycle, so each expected value follows from a single event.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int HR_W      = 5;
    localparam int MN_W      = 6;
    localparam int DIG_W     = 4;
    localparam int CALC_W    = 7;
    localparam int HRS_DAY   = 24;
    localparam int HALF_DAY  = 12;
    localparam int MNS_HR    = 60;
    localparam int SECS_MN   = 60;
    localparam int SEC_ROUND = 50;
    localparam logic [DIG_W-1:0] DIG_BLANK = '1;

    typedef enum logic [1:0] {
        MD_TIME  = 2'd0,
        MD_ALARM = 2'd1,
        MD_SECS  = 2'd2,
        MD_VIEW  = 2'd3
    } disp_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_REPEAT = 2'd2,
        ST_LOCK   = 2'd3
    } set_state_t;

    function automatic logic [DIG_W-1:0] tens_of(input logic [CALC_W-1:0] v);
        return DIG_W'(v / CALC_W'(10));
    endfunction

    function automatic logic [DIG_W-1:0] ones_of(input logic [CALC_W-1:0] v);
        return DIG_W'(v % CALC_W'(10));
    endfunction
endpackage

// File: rtl/tod_set_ctrl.sv
module tod_set_ctrl
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_hr,
    input  logic       btn_mn,
    input  disp_mode_t mode,
    input  logic       tick_half,
    output logic       inc_hr,
    output logic       inc_mn,
    output logic       clr_sec,
    output logic       zero_alarm,
    output logic       hold
);
    set_state_t state_q, state_d;
    logic       hr_q, mn_q;
    logic       rise_hr, rise_mn, any_btn, both_btn, lock_mode, step_mode;

    assign rise_hr   = btn_hr & ~hr_q;
    assign rise_mn   = btn_mn & ~mn_q;
    assign any_btn   = btn_hr | btn_mn;
    assign both_btn  = btn_hr & btn_mn;
    assign lock_mode = (mode == MD_ALARM) || (mode == MD_SECS);
    assign step_mode = (mode == MD_TIME) || (mode == MD_ALARM);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hr_q    <= 1'b0;
            mn_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            hr_q    <= btn_hr;
            mn_q    <= btn_mn;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (both_btn && lock_mode) state_d = ST_LOCK;
                else if (any_btn)          state_d = ST_DELAY;
            end
            ST_DELAY: begin
                if (!any_btn)                   state_d = ST_IDLE;
                else if (both_btn && lock_mode) state_d = ST_LOCK;
                else if (tick_half)             state_d = ST_REPEAT;
            end
            ST_REPEAT: begin
                if (!any_btn)                   state_d = ST_IDLE;
                else if (both_btn && lock_mode) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (!any_btn) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        inc_hr     = 1'b0;
        inc_mn     = 1'b0;
        clr_sec    = 1'b0;
        zero_alarm = 1'b0;
        hold       = (state_q == ST_LOCK) && (mode == MD_SECS);
        unique case (state_q)
            ST_IDLE: begin
                if (both_btn && lock_mode) begin
                    zero_alarm = (mode == MD_ALARM);
                end else if (any_btn) begin
                    clr_sec = (mode == MD_SECS);
                    inc_hr  = step_mode & rise_hr;
                    inc_mn  = step_mode & rise_mn;
                end
            end
            ST_DELAY: begin
                if (both_btn && lock_mode) begin
                    zero_alarm = (mode == MD_ALARM);
                end else if (any_btn) begin
                    inc_hr = step_mode & rise_hr;
                    inc_mn = step_mode & rise_mn;
                end
            end
            ST_REPEAT: begin
                if (both_btn && lock_mode) begin
                    zero_alarm = (mode == MD_ALARM);
                end else if (any_btn) begin
                    inc_hr = step_mode & (rise_hr | (tick_half & btn_hr));
                    inc_mn = step_mode & (rise_mn | (tick_half & btn_mn));
                end
            end
            ST_LOCK: begin
            end
            default: begin
            end
        endcase
    end

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK) && any_btn |=> (state_q == ST_LOCK)); // R6
    AST_ACTIONS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inc_hr | inc_mn, clr_sec, zero_alarm})); // R5
    AST_DELAY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DELAY) && !rise_hr && !rise_mn |-> !inc_hr && !inc_mn); // R4
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
    import tod_pkg::*;
#(
    parameter int HW = HR_W,
    parameter int MW = MN_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_sec,
    input  logic          hold,
    input  logic          inc_hr,
    input  logic          inc_mn,
    input  logic          clr_sec,
    output logic [HW-1:0] hr,
    output logic [MW-1:0] mn,
    output logic [MW-1:0] sc
);
    localparam logic [HW-1:0] HR_LAST = HW'(HRS_DAY - 1);
    localparam logic [MW-1:0] MN_LAST = MW'(MNS_HR - 1);
    localparam logic [MW-1:0] SC_LAST = MW'(SECS_MN - 1);
    localparam logic [MW-1:0] SC_RND  = MW'(SEC_ROUND);

    logic [HW-1:0] hr_q, hr_d, h1;
    logic [MW-1:0] mn_q, mn_d, m1;
    logic [MW-1:0] sc_q, sc_d, s1;

    always_comb begin
        s1 = sc_q;
        m1 = mn_q;
        h1 = hr_q;
        if (tick_sec && !hold) begin
            if (sc_q == SC_LAST) begin
                s1 = '0;
                if (mn_q == MN_LAST) begin
                    m1 = '0;
                    h1 = (hr_q == HR_LAST) ? '0 : hr_q + 1'b1;
                end else begin
                    m1 = mn_q + 1'b1;
                end
            end else begin
                s1 = sc_q + 1'b1;
            end
        end
        sc_d = s1;
        mn_d = m1;
        hr_d = h1;
        if (clr_sec) begin
            sc_d = '0;
            if (s1 >= SC_RND) mn_d = (m1 == MN_LAST) ? '0 : m1 + 1'b1;
        end
        if (inc_mn) mn_d = (m1 == MN_LAST) ? '0 : m1 + 1'b1;
        if (inc_hr) hr_d = (h1 == HR_LAST) ? '0 : h1 + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hr_q <= '0;
            mn_q <= '0;
            sc_q <= '0;
        end else begin
            hr_q <= hr_d;
            mn_q <= mn_d;
            sc_q <= sc_d;
        end
    end

    assign hr = hr_q;
    assign mn = mn_q;
    assign sc = sc_q;

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        sc_q <= SC_LAST); // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        tick_sec && !hold && !clr_sec && (sc_q != SC_LAST) |=> sc_q == $past(sc_q) + 1'b1); // R2
    AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick_sec && !hold && !clr_sec && !inc_hr && !inc_mn &&
        (hr_q == HR_LAST) && (mn_q == MN_LAST) && (sc_q == SC_LAST)
        |=> (hr_q == '0) && (mn_q == '0) && (sc_q == '0)); // R2
    AST_SEC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_sec |=> sc_q == '0); // R7
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold && !clr_sec |=> sc_q == $past(sc_q)); // R8
endmodule

// File: rtl/tod_alarm_reg.sv
module tod_alarm_reg
    import tod_pkg::*;
#(
    parameter int HW = HR_W,
    parameter int MW = MN_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          inc_hr,
    input  logic          inc_mn,
    input  logic          zero_all,
    output logic [HW-1:0] hr,
    output logic [MW-1:0] mn
);
    localparam logic [HW-1:0] HR_LAST = HW'(HRS_DAY - 1);
    localparam logic [MW-1:0] MN_LAST = MW'(MNS_HR - 1);

    logic [HW-1:0] hr_q;
    logic [MW-1:0] mn_q;

    always_ff @(posedge clk) begin
        if (rst || zero_all) begin
            hr_q <= '0;
            mn_q <= '0;
        end else begin
            if (inc_hr) hr_q <= (hr_q == HR_LAST) ? '0 : hr_q + 1'b1;
            if (inc_mn) mn_q <= (mn_q == MN_LAST) ? '0 : mn_q + 1'b1;
        end
    end

    assign hr = hr_q;
    assign mn = mn_q;

    AST_ALARM_ZERO: assert property (@(posedge clk) disable iff (rst)
        zero_all |=> (hr_q == '0) && (mn_q == '0)); // R6
    AST_ALARM_RANGE: assert property (@(posedge clk) disable iff (rst)
        (hr_q <= HR_LAST) && (mn_q <= MN_LAST)); // R5
    AST_ALARM_STILL: assert property (@(posedge clk) disable iff (rst)
        !inc_hr && !inc_mn && !zero_all |=> $stable(hr_q) && $stable(mn_q)); // R5
endmodule

// File: rtl/tod_display.sv
module tod_display
    import tod_pkg::*;
#(
    parameter int HW = HR_W,
    parameter int MW = MN_W,
    parameter int DW = DIG_W
)(
    input  logic          clk,
    input  logic          rst,
    input  disp_mode_t    mode,
    input  logic          fmt_12h,
    input  logic          tick_half,
    input  logic          btn_any,
    input  logic [HW-1:0] t_hr,
    input  logic [MW-1:0] t_mn,
    input  logic [MW-1:0] t_sc,
    input  logic [HW-1:0] a_hr,
    input  logic [MW-1:0] a_mn,
    output logic [DW-1:0] dig [4],
    output logic          pm,
    output logic          seg_on,
    output logic          pwr_fail
);
    localparam logic [HW-1:0] HALF = HW'(HALF_DAY);

    logic [HW-1:0] src_hr, hr12, hv;
    logic [MW-1:0] src_mn;
    logic          pf_q, blink_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_q    <= 1'b1;
            blink_q <= 1'b1;
        end else begin
            if (btn_any)   pf_q    <= 1'b0;
            if (tick_half) blink_q <= ~blink_q;
        end
    end

    always_comb begin
        src_hr = (mode == MD_ALARM) ? a_hr : t_hr;
        src_mn = (mode == MD_ALARM) ? a_mn : t_mn;
        if (src_hr == '0)       hr12 = HALF;
        else if (src_hr > HALF) hr12 = src_hr - HALF;
        else                    hr12 = src_hr;
        hv = fmt_12h ? hr12 : src_hr;
        if (mode == MD_SECS) begin
            dig[3] = DW'(DIG_BLANK);
            dig[2] = DW'(ones_of(CALC_W'(t_mn)));
            dig[1] = DW'(tens_of(CALC_W'(t_sc)));
            dig[0] = DW'(ones_of(CALC_W'(t_sc)));
        end else begin
            dig[3] = DW'(tens_of(CALC_W'(hv)));
            dig[2] = DW'(ones_of(CALC_W'(hv)));
            dig[1] = DW'(tens_of(CALC_W'(src_mn)));
            dig[0] = DW'(ones_of(CALC_W'(src_mn)));
        end
        pm = fmt_12h && (mode != MD_SECS) && (src_hr >= HALF);
    end

    assign seg_on   = !pf_q || blink_q;
    assign pwr_fail = pf_q;

    AST_PF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        btn_any |=> !pwr_fail); // R13
    AST_PF_STICKY: assert property (@(posedge clk) disable iff (rst)
        !pwr_fail |=> !pwr_fail); // R13
    AST_BLINK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        pwr_fail && tick_half && !btn_any |=> seg_on != $past(seg_on)); // R13
endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_1hz,
    input  logic               tick_2hz,
    input  logic               set_hr,
    input  logic               set_min,
    input  logic               sel_alarm,
    input  logic               sel_aux,
    input  logic               fmt_12h,
    output logic [HR_W-1:0]    hours,
    output logic [MN_W-1:0]    minutes,
    output logic [MN_W-1:0]    seconds,
    output logic [HR_W-1:0]    alarm_hours,
    output logic [MN_W-1:0]    alarm_minutes,
    output logic               pm,
    output logic [DIG_W-1:0]   digit3,
    output logic [DIG_W-1:0]   digit2,
    output logic [DIG_W-1:0]   digit1,
    output logic [DIG_W-1:0]   digit0,
    output logic               seg_on,
    output logic               pwr_fail
);
    disp_mode_t       mode;
    logic             btn_hr, btn_mn;
    logic             inc_hr, inc_mn, clr_sec, zero_alarm, hold;
    logic [DIG_W-1:0] dig [4];

    always_comb begin
        unique case ({sel_aux, sel_alarm})
            2'b00:   mode = MD_TIME;
            2'b01:   mode = MD_ALARM;
            2'b11:   mode = MD_SECS;
            default: mode = MD_VIEW;
        endcase
    end

    assign btn_hr = set_hr  && (mode != MD_VIEW);
    assign btn_mn = set_min && (mode != MD_VIEW);

    tod_set_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .btn_hr     (btn_hr),
        .btn_mn     (btn_mn),
        .mode       (mode),
        .tick_half  (tick_2hz),
        .inc_hr     (inc_hr),
        .inc_mn     (inc_mn),
        .clr_sec    (clr_sec),
        .zero_alarm (zero_alarm),
        .hold       (hold)
    );

    tod_time_core #(.HW(HR_W), .MW(MN_W)) u_time (
        .clk      (clk),
        .rst      (rst),
        .tick_sec (tick_1hz),
        .hold     (hold),
        .inc_hr   (inc_hr && (mode == MD_TIME)),
        .inc_mn   (inc_mn && (mode == MD_TIME)),
        .clr_sec  (clr_sec),
        .hr       (hours),
        .mn       (minutes),
        .sc       (seconds)
    );

    tod_alarm_reg #(.HW(HR_W), .MW(MN_W)) u_alarm (
        .clk      (clk),
        .rst      (rst),
        .inc_hr   (inc_hr && (mode == MD_ALARM)),
        .inc_mn   (inc_mn && (mode == MD_ALARM)),
        .zero_all (zero_alarm),
        .hr       (alarm_hours),
        .mn       (alarm_minutes)
    );

    tod_display #(.HW(HR_W), .MW(MN_W), .DW(DIG_W)) u_disp (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .fmt_12h   (fmt_12h),
        .tick_half (tick_2hz),
        .btn_any   (set_hr || set_min),
        .t_hr      (hours),
        .t_mn      (minutes),
        .t_sc      (seconds),
        .a_hr      (alarm_hours),
        .a_mn      (alarm_minutes),
        .dig       (dig),
        .pm        (pm),
        .seg_on    (seg_on),
        .pwr_fail  (pwr_fail)
    );

    assign digit3 = dig[3];
    assign digit2 = dig[2];
    assign digit1 = dig[1];
    assign digit0 = dig[0];

    AST_VIEW_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_VIEW) && !tick_1hz |=> $stable(hours) && $stable(minutes)); // R12
endmodule

// File: tb/tod_keeper_tb.sv
module tod_keeper_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0, tick_2hz = 1'b0;
    logic       set_hr = 1'b0, set_min = 1'b0;
    logic       sel_alarm = 1'b0, sel_aux = 1'b0, fmt_12h = 1'b0;
    logic [4:0] hours, alarm_hours;
    logic [5:0] minutes, seconds, alarm_minutes;
    logic       pm, seg_on, pwr_fail;
    logic [3:0] digit3, digit2, digit1, digit0;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done  = 1'b0;
    int eh = 0, em = 0, es = 0, eah = 0, eam = 0;

    tod_keeper u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_2hz(tick_2hz),
        .set_hr(set_hr), .set_min(set_min), .sel_alarm(sel_alarm),
        .sel_aux(sel_aux), .fmt_12h(fmt_12h), .hours(hours),
        .minutes(minutes), .seconds(seconds), .alarm_hours(alarm_hours),
        .alarm_minutes(alarm_minutes), .pm(pm), .digit3(digit3),
        .digit2(digit2), .digit1(digit1), .digit0(digit0),
        .seg_on(seg_on), .pwr_fail(pwr_fail)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic sec_tick();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic half_tick();
        tick_2hz = 1'b1;
        @(negedge clk);
        tick_2hz = 1'b0;
    endtask

    task automatic push(input logic h, input logic m);
        set_hr  = h;
        set_min = m;
        @(negedge clk);
    endtask

    task automatic let_go();
        set_hr  = 1'b0;
        set_min = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_time(input string tag);
        chk({tag, " hours"},   int'(hours),   eh);
        chk({tag, " minutes"}, int'(minutes), em);
        chk({tag, " seconds"}, int'(seconds), es);
    endtask

    function automatic int h12(input int h);
        return (h % 12 == 0) ? 12 : h % 12;
    endfunction

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        chk_time("R1");
        chk("R1 alarm_hours", int'(alarm_hours), 0);
        chk("R1 alarm_minutes", int'(alarm_minutes), 0);
        chk("R1 pwr_fail", int'(pwr_fail), 1);
        chk("R1 seg_on", int'(seg_on), 1);
        chk("R1 digit3", int'(digit3), 0);
        chk("R1 digit0", int'(digit0), 0);

        // R13 blink while flag set
        half_tick();
        chk("R13 seg_on off", int'(seg_on), 0);
        half_tick();
        chk("R13 seg_on on", int'(seg_on), 1);
        chk("R13 flag kept", int'(pwr_fail), 1);

        // R13 + R3 first minute press
        push(1'b0, 1'b1);
        em = 1;
        chk("R13 flag cleared", int'(pwr_fail), 0);
        chk("R13 seg_on steady", int'(seg_on), 1);
        chk("R3 minute press", int'(minutes), em);
        let_go();

        // R3 / R9 minute sweep, wrap without hour carry
        for (int k = 2; k <= 60; k++) begin
            push(1'b0, 1'b1);
            let_go();
            em = k % 60;
            chk("R3 minute sweep", int'(minutes), em);
            chk("R3 no hour carry", int'(hours), 0);
            chk("R9 digit1", int'(digit1), em / 10);
            chk("R9 digit0", int'(digit0), em % 10);
        end

        // R3 / R9 / R11 hour sweep in both formats
        for (int k = 1; k <= 24; k++) begin
            push(1'b1, 1'b0);
            let_go();
            eh = k % 24;
            fmt_12h = 1'b0;
            cyc();
            chk("R3 hour sweep", int'(hours), eh);
            chk("R9 digit3 24h", int'(digit3), eh / 10);
            chk("R9 digit2 24h", int'(digit2), eh % 10);
            chk("R11 pm 24h", int'(pm), 0);
            fmt_12h = 1'b1;
            cyc();
            chk("R9 digit3 12h", int'(digit3), h12(eh) / 10);
            chk("R9 digit2 12h", int'(digit2), h12(eh) % 10);
            chk("R11 pm 12h", int'(pm), (eh >= 12) ? 1 : 0);
            fmt_12h = 1'b0;
        end

        // R3 both buttons in time mode
        push(1'b1, 1'b1);
        eh = 1; em = 1;
        chk_time("R3 both");
        let_go();

        // R4 auto-repeat
        push(1'b1, 1'b0);
        eh = 2;
        chk("R4 immediate", int'(hours), eh);
        half_tick();
        chk("R4 first tick idle", int'(hours), eh);
        half_tick();
        eh = 3;
        chk("R4 repeat one", int'(hours), eh);
        half_tick();
        eh = 4;
        chk("R4 repeat two", int'(hours), eh);
        let_go();

        // R2 / R10 seconds sweep in seconds mode
        sel_alarm = 1'b1; sel_aux = 1'b1;
        cyc();
        for (int k = 1; k <= 60; k++) begin
            sec_tick();
            es = k % 60;
            if (k == 60) em = 2;
            chk_time("R2 tick");
            chk("R10 digit3 blank", int'(digit3), 15);
            chk("R10 digit2", int'(digit2), em % 10);
            chk("R10 digit1", int'(digit1), es / 10);
            chk("R10 digit0", int'(digit0), es % 10);
        end

        // R7 seconds clear with and without rounding
        repeat (55) sec_tick();
        es = 55;
        chk_time("R7 before");
        push(1'b1, 1'b0);
        es = 0; em = 3;
        chk_time("R7 round up");
        let_go();
        repeat (10) sec_tick();
        push(1'b0, 1'b1);
        es = 0;
        chk_time("R7 plain clear");
        let_go();

        // R8 freeze while both held
        push(1'b1, 1'b1);
        chk_time("R8 no clear");
        repeat (3) sec_tick();
        chk_time("R8 frozen");
        set_hr = 1'b0;
        cyc();
        sec_tick();
        chk_time("R8 still locked");
        let_go();
        sec_tick();
        es = 1;
        chk_time("R8 resumed");

        // R5 alarm set
        sel_aux = 1'b0; sel_alarm = 1'b1;
        cyc();
        repeat (3) begin push(1'b1, 1'b0); let_go(); end
        repeat (2) begin push(1'b0, 1'b1); let_go(); end
        eah = 3; eam = 2;
        chk("R5 alarm_hours", int'(alarm_hours), eah);
        chk("R5 alarm_minutes", int'(alarm_minutes), eam);
        chk_time("R5 time untouched");
        chk("R9 alarm digit3", int'(digit3), 0);
        chk("R9 alarm digit2", int'(digit2), 3);
        chk("R9 alarm digit1", int'(digit1), 0);
        chk("R9 alarm digit0", int'(digit0), 2);
        repeat (12) begin push(1'b1, 1'b0); let_go(); end
        eah = 15;
        fmt_12h = 1'b1;
        cyc();
        chk("R11 alarm pm", int'(pm), 1);
        chk("R9 alarm 12h digit3", int'(digit3), 0);
        chk("R9 alarm 12h digit2", int'(digit2), 3);
        fmt_12h = 1'b0;
        cyc();
        chk("R9 alarm 24h digit3", int'(digit3), 1);
        chk("R9 alarm 24h digit2", int'(digit2), 5);
        chk("R11 alarm pm 24h", int'(pm), 0);

        // R6 two-button alarm reset and lock
        push(1'b1, 1'b1);
        eah = 0; eam = 0;
        chk("R6 alarm_hours zero", int'(alarm_hours), eah);
        chk("R6 alarm_minutes zero", int'(alarm_minutes), eam);
        fmt_12h = 1'b1;
        cyc();
        chk("R6 12h digit3", int'(digit3), 1);
        chk("R6 12h digit2", int'(digit2), 2);
        chk("R6 12h digit1", int'(digit1), 0);
        chk("R6 12h pm", int'(pm), 0);
        fmt_12h = 1'b0;
        set_hr = 1'b0;
        cyc();
        set_hr = 1'b1;
        cyc();
        chk("R6 locked", int'(alarm_hours), 0);
        let_go();
        push(1'b1, 1'b0);
        eah = 1;
        chk("R6 unlocked", int'(alarm_hours), eah);
        let_go();

        // R12 view mode ignores buttons
        sel_alarm = 1'b0; sel_aux = 1'b1;
        cyc();
        push(1'b1, 1'b1);
        let_go();
        push(1'b0, 1'b1);
        let_go();
        chk_time("R12 view");
        chk("R12 alarm kept", int'(alarm_hours), eah);
        chk("R12 digit2", int'(digit2), 4);
        chk("R12 digit0", int'(digit0), 3);

        // R2 day rollover
        sel_aux = 1'b0;
        cyc();
        repeat (19) begin push(1'b1, 1'b0); let_go(); end
        repeat (56) begin push(1'b0, 1'b1); let_go(); end
        eh = 23; em = 59;
        chk_time("R3 preset");
        sel_alarm = 1'b1; sel_aux = 1'b1;
        cyc();
        repeat (58) sec_tick();
        es = 59;
        chk_time("R2 pre-rollover");
        fmt_12h = 1'b1;
        cyc();
        chk("R11 pm seconds mode", int'(pm), 0);
        sec_tick();
        eh = 0; em = 0; es = 0;
        chk_time("R2 rollover");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule